// File: doc/BRIEF.md
# Cartridge Read Front-End with Identification Query Mode

This block sits between a host access port and a cartridge ROM. It serves host reads from one of three places. An identification table answers while a flash-style query mode is on and the address falls in a present bank. Otherwise the data comes from the external decryptor when decryption is enabled, and from the plain ROM when it is not. Reads on the ROM path that land at or past the end of the ROM return zero. Two fixed command writes turn the query mode on and off.

The host programs a transfer offset. Bit 30 of that offset turns decryption on. Any write of the offset drops the transfer-ready state. The next read on the ROM path then loads the ROM position from the offset, with bits 31:29 and bit 0 cleared. In that same cycle it raises the decryptor restart strobe when decryption is on. After that read the position advances by the access size (2 or 4 bytes) when auto-increment is requested. The ROM and the decryptor are outside the block. It drives the ROM address and the restart strobe combinationally during the read cycle and takes their data back in that same cycle.

Top module: `cart_read_frontend`

## Requirements
- R1: After reset, query mode is off, decryption is off, transfer-ready is low, `rd_valid` is low and `rom_addr` is zero.
- R2: A command write with data 0x0098 at low address 0x00AA turns query mode on from the next cycle.
- R3: A command write with data 0x00F0 at low address 0x0000 turns query mode off. Every other command write leaves query mode unchanged.
- R4: In query mode, a read is a table hit when address bits 28:26 are less than bits 6:0 of the effective cartridge ID. A hit returns table word number `rd_addr[15:1]`, or zero past the table depth. A hit leaves `rom_addr` and transfer-ready unchanged. A read that misses takes the ROM path.
- R5: A cartridge ID of 0x0000 is treated as 0x5504, which gives a bank limit of 4.
- R6: Bit 30 of the written offset drives `enc_active`. While it is set, ROM-path reads return `dec_rdata`.
- R7: An offset write clears transfer-ready. The next ROM-path read presents `rom_addr` = offset & 0x1FFFFFFE and sets transfer-ready.
- R8: `dec_restart` is high only during a ROM-path read made while transfer-ready is low and decryption is on.
- R9: With `auto_inc` high, a ROM-path read moves `rom_addr` forward by 4 when `rd_size4` is high and by 2 when it is low. With `auto_inc` low, or with no read, the position holds.
- R10: An unencrypted ROM-path read whose address is at or beyond `ROM_BYTES` returns zero.
- R11: Read data is registered. `rd_valid` is high for exactly the cycle after `rd_en`. A 2-byte read returns zero in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command write strobe |
| cmd_wr_addr | input | 16 | Low 16 address bits of the command write |
| cmd_wr_data | input | DATA_W | Command write data |
| off_wr_en | input | 1 | Transfer offset write strobe |
| off_wr_data | input | 32 | Transfer offset; bit 30 enables decryption |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 32 | Host read address (bits 28:26 and 15:1 used) |
| rd_size4 | input | 1 | 1 = 4-byte access, 0 = 2-byte access |
| auto_inc | input | 1 | Advance position after a ROM-path read |
| cart_id | input | 16 | Cartridge ID; zero selects the default |
| rom_rdata | input | DATA_W | Plain ROM data at `rom_addr` |
| dec_rdata | input | DATA_W | Decryptor output for the current position |
| rom_addr | output | AW | Current ROM byte position (combinational) |
| dec_restart | output | 1 | Decryptor restart strobe (combinational) |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid |
| query_active | output | 1 | Query mode state |
| enc_active | output | 1 | Decryption enable state |
| xfer_ready | output | 1 | Transfer-ready state |

## Verification
The assertions assume that an offset write and a read never share a cycle. If they do, the offset write takes priority and the read's position update is dropped. The stimulus always issues them on separate cycles. The assertions also assume that `cart_id` is stable while query reads are in flight, so the bench changes it only between read sweeps. `rom_rdata` and `dec_rdata` are taken to answer in the same cycle as `rom_addr`. The bench models both as pure functions of `rom_addr`, which meets that assumption.

// File: rtl/cartfe_pkg.sv
package cartfe_pkg;

   localparam logic [15:0] CART_ID_DEFAULT = 16'h5504;
   localparam logic [15:0] QRY_ON_ADDR     = 16'h00AA;
   localparam logic [15:0] QRY_ON_DATA     = 16'h0098;
   localparam logic [15:0] QRY_OFF_ADDR    = 16'h0000;
   localparam logic [15:0] QRY_OFF_DATA    = 16'h00F0;
   localparam int          ID_LIMIT_W      = 7;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_TABLE = 2'd1,
      SRC_PLAIN = 2'd2,
      SRC_CRYPT = 2'd3
   } rd_src_e;

   function automatic logic [15:0] resolve_id(input logic [15:0] raw);
      return (raw == 16'h0000) ? CART_ID_DEFAULT : raw;
   endfunction

endpackage

// File: rtl/cartfe_cmd_decode.sv
module cartfe_cmd_decode
   import cartfe_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              query_active
);

   localparam logic [DATA_W-1:0] ON_D  = DATA_W'(QRY_ON_DATA);
   localparam logic [DATA_W-1:0] OFF_D = DATA_W'(QRY_OFF_DATA);

   if (DATA_W < 16) begin : g_chk_w
      $error("cartfe_cmd_decode: DATA_W must be at least 16");
   end

   logic go_on, go_off, q_q;

   always_comb begin
      go_on  = wr_en && (wr_addr == QRY_ON_ADDR)  && (wr_data == ON_D);
      go_off = wr_en && (wr_addr == QRY_OFF_ADDR) && (wr_data == OFF_D);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      q_q <= 1'b0;
      else if (go_on)  q_q <= 1'b1;
      else if (go_off) q_q <= 1'b0;
   end

   assign query_active = q_q;

   assert_query_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h00AA && wr_data == DATA_W'(16'h0098)) |=> query_active);

   assert_query_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h0000 && wr_data == DATA_W'(16'h00F0)) |=> !query_active);

   assert_query_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || ((wr_addr != 16'h00AA || wr_data != DATA_W'(16'h0098)) &&
                  (wr_addr != 16'h0000 || wr_data != DATA_W'(16'h00F0))))
      |=> $stable(query_active));

endmodule

// File: rtl/cartfe_query_table.sv
module cartfe_query_table
   import cartfe_pkg::*;
#(
   parameter int                      TBL_WORDS = 8,
   parameter logic [TBL_WORDS*16-1:0] TBL_INIT  = '0,
   parameter int                      BANK_W    = 3
) (
   input  logic              query_active,
   input  logic [BANK_W-1:0] bank,
   input  logic [14:0]       word_idx,
   input  logic [15:0]       cart_id,
   output logic              hit,
   output logic [15:0]       word
);

   localparam int SEL_W = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1;

   if (TBL_WORDS < 1 || TBL_WORDS > 32768) begin : g_chk_depth
      $error("cartfe_query_table: TBL_WORDS out of range");
   end
   if (BANK_W < 1 || BANK_W > ID_LIMIT_W) begin : g_chk_bank
      $error("cartfe_query_table: BANK_W out of range");
   end

   logic [15:0] rom_words [TBL_WORDS];

   for (genvar g = 0; g < TBL_WORDS; g++) begin : g_word
      assign rom_words[g] = TBL_INIT[g*16 +: 16];
   end

   logic [15:0]           id_eff;
   logic [ID_LIMIT_W-1:0] limit;
   logic                  in_range;
   logic [SEL_W-1:0]      sel;

   always_comb begin
      id_eff   = resolve_id(cart_id);
      limit    = id_eff[ID_LIMIT_W-1:0];
      hit      = query_active && (ID_LIMIT_W'(bank) < limit);
      in_range = (32'(word_idx) < TBL_WORDS);
      sel      = word_idx[SEL_W-1:0];
      word     = in_range ? rom_words[sel] : 16'h0000;
   end

endmodule

// File: rtl/cartfe_xfer_ctrl.sv
module cartfe_xfer_ctrl #(
   parameter int AW      = 29,
   parameter int ENC_BIT = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          off_wr_en,
   input  logic [31:0]   off_wr_data,
   input  logic          rd_go,
   input  logic          rd_size4,
   input  logic          auto_inc,
   output logic          enc_active,
   output logic          xfer_ready,
   output logic [AW-1:0] cur_addr,
   output logic          dec_restart
);

   localparam logic [31:0] LOAD_MASK = 32'((64'd1 << AW) - 64'd1) & ~32'd1;

   if (AW < 2 || AW > 31) begin : g_chk_aw
      $error("cartfe_xfer_ctrl: AW out of range");
   end
   if (ENC_BIT < AW || ENC_BIT > 31) begin : g_chk_enc
      $error("cartfe_xfer_ctrl: ENC_BIT must sit above the address field");
   end

   logic [31:0]   off_q;
   logic          rdy_q;
   logic [AW-1:0] pos_q;
   logic [31:0]   masked;
   logic [AW-1:0] load_addr;
   logic [AW-1:0] step;

   always_comb begin
      masked      = off_q & LOAD_MASK;
      load_addr   = masked[AW-1:0];
      cur_addr    = rdy_q ? pos_q : load_addr;
      step        = rd_size4 ? AW'(4) : AW'(2);
      enc_active  = off_q[ENC_BIT];
      xfer_ready  = rdy_q;
      dec_restart = rd_go && !rdy_q && off_q[ENC_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q <= '0;
         rdy_q <= 1'b0;
         pos_q <= '0;
      end else if (off_wr_en) begin
         off_q <= off_wr_data;
         rdy_q <= 1'b0;
      end else if (rd_go) begin
         rdy_q <= 1'b1;
         pos_q <= auto_inc ? (cur_addr + step) : cur_addr;
      end
   end

   assert_offset_write_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      off_wr_en |=> !xfer_ready);

   assert_first_read_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !off_wr_en && !xfer_ready && !auto_inc)
      |=> (xfer_ready && cur_addr == $past(load_addr)));

   assert_restart_then_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_restart && !off_wr_en) |=> (xfer_ready && !dec_restart));

   assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !off_wr_en && auto_inc) |=> cur_addr == $past(cur_addr) + $past(step));

   assert_position_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_go && !off_wr_en) |=> $stable(cur_addr));

endmodule

// File: rtl/cart_read_frontend.sv
module cart_read_frontend
   import cartfe_pkg::*;
#(
   parameter int                      DATA_W    = 32,
   parameter int                      AW        = 29,
   parameter int                      ENC_BIT   = 30,
   parameter int                      BANK_LSB  = 26,
   parameter int                      BANK_W    = 3,
   parameter logic [31:0]             ROM_BYTES = 32'h0100_0000,
   parameter int                      TBL_WORDS = 8,
   parameter logic [TBL_WORDS*16-1:0] TBL_INIT  =
      128'h0000_0040_0000_0002_0059_0052_0051_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_en,
   input  logic [15:0]       cmd_wr_addr,
   input  logic [DATA_W-1:0] cmd_wr_data,
   input  logic              off_wr_en,
   input  logic [31:0]       off_wr_data,
   input  logic              rd_en,
   input  logic [31:0]       rd_addr,
   input  logic              rd_size4,
   input  logic              auto_inc,
   input  logic [15:0]       cart_id,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [DATA_W-1:0] dec_rdata,
   output logic [AW-1:0]     rom_addr,
   output logic              dec_restart,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              query_active,
   output logic              enc_active,
   output logic              xfer_ready
);

   if (DATA_W < 32) begin : g_chk_dw
      $error("cart_read_frontend: DATA_W must hold a 4-byte access");
   end
   if (BANK_LSB + BANK_W > 32 || BANK_LSB < 16) begin : g_chk_bank
      $error("cart_read_frontend: bank field must sit above the table index");
   end

   logic        tbl_hit;
   logic [15:0] tbl_word;
   logic        rom_go;
   logic        beyond;
   rd_src_e     src;
   logic [DATA_W-1:0] raw_data, next_data;

   cartfe_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (cmd_wr_en),
      .wr_addr      (cmd_wr_addr),
      .wr_data      (cmd_wr_data),
      .query_active (query_active)
   );

   cartfe_query_table #(
      .TBL_WORDS (TBL_WORDS),
      .TBL_INIT  (TBL_INIT),
      .BANK_W    (BANK_W)
   ) u_tbl (
      .query_active (query_active),
      .bank         (rd_addr[BANK_LSB +: BANK_W]),
      .word_idx     (rd_addr[15:1]),
      .cart_id      (cart_id),
      .hit          (tbl_hit),
      .word         (tbl_word)
   );

   assign rom_go = rd_en && !tbl_hit;

   cartfe_xfer_ctrl #(.AW(AW), .ENC_BIT(ENC_BIT)) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .off_wr_en   (off_wr_en),
      .off_wr_data (off_wr_data),
      .rd_go       (rom_go),
      .rd_size4    (rd_size4),
      .auto_inc    (auto_inc),
      .enc_active  (enc_active),
      .xfer_ready  (xfer_ready),
      .cur_addr    (rom_addr),
      .dec_restart (dec_restart)
   );

   always_comb begin
      beyond = (32'(rom_addr) >= ROM_BYTES);
      if (tbl_hit)         src = SRC_TABLE;
      else if (enc_active) src = SRC_CRYPT;
      else                 src = SRC_PLAIN;
      case (src)
         SRC_TABLE: raw_data = DATA_W'(tbl_word);
         SRC_CRYPT: raw_data = dec_rdata;
         SRC_PLAIN: raw_data = beyond ? '0 : rom_rdata;
         default:   raw_data = '0;
      endcase
      next_data = rd_size4 ? raw_data : DATA_W'(raw_data[15:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= next_data;
      end
   end

   assert_valid_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   assert_no_valid_without_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   assert_half_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_size4) |=> (rd_data[DATA_W-1:16] == '0));

   assert_beyond_rom_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_go && !enc_active && (32'(rom_addr) >= ROM_BYTES)) |=> (rd_data == '0));

   assert_table_no_side_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && tbl_hit && !off_wr_en) |=> ($stable(xfer_ready) && $stable(rom_addr)));

   assert_restart_needs_rom_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_restart |-> (rd_en && !query_active) || (rd_en && query_active));

   assert_crypt_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_go && enc_active && rd_size4) |=> (rd_data == $past(dec_rdata)));

endmodule

// File: tb/cart_read_frontend_test.sv
`timescale 1ns/1ps
module cart_read_frontend_test;

   localparam int          TW   = 8;
   localparam logic [31:0] ROMB = 32'h100;

   function automatic logic [15:0] tword(input int i);
      return 16'hA000 + 16'(i) * 16'h0111;
   endfunction

   function automatic logic [TW*16-1:0] build_tbl();
      logic [TW*16-1:0] v;
      v = '0;
      for (int i = 0; i < TW; i++) v[i*16 +: 16] = tword(i);
      return v;
   endfunction

   localparam logic [TW*16-1:0] TBL = build_tbl();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr_en = 1'b0;
   logic [15:0] cmd_wr_addr = '0;
   logic [31:0] cmd_wr_data = '0;
   logic        off_wr_en = 1'b0;
   logic [31:0] off_wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_addr = '0;
   logic        rd_size4 = 1'b0;
   logic        auto_inc = 1'b0;
   logic [15:0] cart_id = 16'h0003;
   logic [31:0] rom_rdata, dec_rdata;
   logic [28:0] rom_addr;
   logic        dec_restart;
   logic [31:0] rd_data;
   logic        rd_valid, query_active, enc_active, xfer_ready;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   cart_read_frontend #(
      .ROM_BYTES (ROMB),
      .TBL_WORDS (TW),
      .TBL_INIT  (TBL)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr_en(cmd_wr_en), .cmd_wr_addr(cmd_wr_addr), .cmd_wr_data(cmd_wr_data),
      .off_wr_en(off_wr_en), .off_wr_data(off_wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_size4(rd_size4), .auto_inc(auto_inc),
      .cart_id(cart_id), .rom_rdata(rom_rdata), .dec_rdata(dec_rdata),
      .rom_addr(rom_addr), .dec_restart(dec_restart), .rd_data(rd_data),
      .rd_valid(rd_valid), .query_active(query_active), .enc_active(enc_active),
      .xfer_ready(xfer_ready)
   );

   function automatic logic [31:0] plain_of(input logic [28:0] a);
      return {a[15:0] ^ 16'h5A5A, a[15:0]};
   endfunction
   function automatic logic [31:0] crypt_of(input logic [28:0] a);
      return {16'hDEC0, ~a[15:0]};
   endfunction

   always_comb begin
      rom_rdata = plain_of(rom_addr);
      dec_rdata = crypt_of(rom_addr);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [15:0] a, input logic [31:0] d);
      cmd_wr_en = 1'b1; cmd_wr_addr = a; cmd_wr_data = d;
      @(negedge clk);
      cmd_wr_en = 1'b0;
   endtask

   task automatic set_off(input logic [31:0] v);
      off_wr_en = 1'b1; off_wr_data = v;
      @(negedge clk);
      off_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, input logic s4, input logic ai,
                     output logic [31:0] d, output logic [28:0] ra, output logic rs);
      rd_en = 1'b1; rd_addr = a; rd_size4 = s4; auto_inc = ai;
      #1;
      ra = rom_addr;
      rs = dec_restart;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
      chk("R11 valid", {31'd0, rd_valid}, 32'd1);
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [28:0] ra;
      logic        rs;
      logic [28:0] p;
      logic [31:0] e;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 query", {31'd0, query_active}, 32'd0);
      chk("R1 enc", {31'd0, enc_active}, 32'd0);
      chk("R1 ready", {31'd0, xfer_ready}, 32'd0);
      chk("R1 valid", {31'd0, rd_valid}, 32'd0);
      chk("R1 addr", 32'(rom_addr), 32'd0);

      // R7, R10: plain sweep across ROM end, 2-byte auto-increment
      set_off(32'h2000_00F3);
      chk("R7 ready cleared", {31'd0, xfer_ready}, 32'd0);
      chk("R6 enc off", {31'd0, enc_active}, 32'd0);
      for (int k = 0; k < 12; k++) begin
         p = 29'h0F2 + 29'(2 * k);
         rd(32'h0, 1'b0, 1'b1, d, ra, rs);
         chk("R7 R9 position", 32'(ra), 32'(p));
         chk("R8 no restart plain", {31'd0, rs}, 32'd0);
         e = (32'(p) < ROMB) ? {16'h0, plain_of(p)[15:0]} : 32'h0;
         chk("R10 R11 plain data", d, e);
      end
      chk("R7 ready set", {31'd0, xfer_ready}, 32'd1);

      // R9: 4-byte stride, then hold without auto-increment
      set_off(32'h0000_0080);
      for (int k = 0; k < 6; k++) begin
         p = 29'h080 + 29'(4 * k);
         rd(32'h0, 1'b1, 1'b1, d, ra, rs);
         chk("R9 stride4", 32'(ra), 32'(p));
         chk("R9 data4", d, plain_of(p));
      end
      rd(32'h0, 1'b1, 1'b0, d, ra, rs);
      rd(32'h0, 1'b1, 1'b0, d, ra, rs);
      chk("R9 hold", 32'(ra), 32'h098);
      chk("R9 hold pos", 32'(rom_addr), 32'h098);

      // R6, R8: encrypted stream and restart
      set_off(32'h4000_0010);
      chk("R6 enc on", {31'd0, enc_active}, 32'd1);
      rd(32'h0, 1'b1, 1'b1, d, ra, rs);
      chk("R8 restart first", {31'd0, rs}, 32'd1);
      chk("R7 load enc", 32'(ra), 32'h010);
      chk("R6 crypt data", d, crypt_of(29'h010));
      rd(32'h0, 1'b1, 1'b1, d, ra, rs);
      chk("R8 no restart second", {31'd0, rs}, 32'd0);
      chk("R9 enc advance", 32'(ra), 32'h014);
      set_off(32'h4000_0010);
      rd(32'h0, 1'b0, 1'b0, d, ra, rs);
      chk("R7 R8 restart again", {31'd0, rs}, 32'd1);
      chk("R7 reload", 32'(ra), 32'h010);

      // R2, R3: command decode
      cmd(16'h00AA, 32'h0099);
      chk("R3 wrong data ignored", {31'd0, query_active}, 32'd0);
      cmd(16'h00AB, 32'h0098);
      chk("R3 wrong addr ignored", {31'd0, query_active}, 32'd0);
      cmd(16'h00AA, 32'h0098);
      chk("R2 enter", {31'd0, query_active}, 32'd1);
      cmd(16'h00AB, 32'h00F0);
      chk("R3 other write holds", {31'd0, query_active}, 32'd1);

      // R4: bank gate x table index sweep, cart ID 3
      cart_id = 16'h0003;
      for (int b = 0; b < 8; b++) begin
         for (int i = 0; i < TW + 1; i++) begin
            rd((32'(b) << 26) | (32'(i) << 1), 1'b0, 1'b0, d, ra, rs);
            if (b < 3) e = (i < TW) ? {16'h0, tword(i)} : 32'h0;
            else       e = {16'h0, crypt_of(29'h010)[15:0]};
            chk("R4 gate/table", d, e);
            chk("R4 position kept", 32'(ra), 32'h010);
         end
      end

      // R5: zero ID gives limit 4; ID with zero low bits gives none
      cart_id = 16'h0000;
      for (int b = 0; b < 8; b++) begin
         rd(32'(b) << 26, 1'b0, 1'b0, d, ra, rs);
         e = (b < 4) ? {16'h0, tword(0)} : {16'h0, crypt_of(29'h010)[15:0]};
         chk("R5 default id", d, e);
      end
      cart_id = 16'h0080;
      rd(32'h0, 1'b0, 1'b0, d, ra, rs);
      chk("R4 limit zero", d, {16'h0, crypt_of(29'h010)[15:0]});

      // R4: table hit does not touch transfer-ready
      cart_id = 16'h0003;
      set_off(32'h0000_0020);
      rd(32'h2, 1'b0, 1'b1, d, ra, rs);
      chk("R4 table hit", d, {16'h0, tword(1)});
      chk("R4 ready untouched", {31'd0, xfer_ready}, 32'd0);
      chk("R4 addr untouched", 32'(rom_addr), 32'h020);

      // R3: leave query mode, next read goes to ROM
      cmd(16'h0000, 32'h00F0);
      chk("R3 leave", {31'd0, query_active}, 32'd0);
      rd(32'h2, 1'b0, 1'b1, d, ra, rs);
      chk("R7 plain load", 32'(ra), 32'h020);
      chk("R4 miss after leave", d, {16'h0, plain_of(29'h020)[15:0]});
      chk("R7 ready after", {31'd0, xfer_ready}, 32'd1);

      @(negedge clk);
      chk("R11 valid drops", {31'd0, rd_valid}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule